// File: doc/BRIEF.md
# Sync Lock and Loss-of-Signal Qualifier

This block sits behind a sync slicer. It samples an active-low composite sync stream on a fixed oscillator clock and decides whether a valid line-rate sync is present. It drives a loss-of-signal flag and an enable that blanks the downstream sync outputs. While no valid input is present, it also drives a free-running, line-rate strobe. That strobe stands in for the back-porch restore pulse, so the clamp loop keeps running while there is no signal.

A selectable minimum-width filter comes first. It suppresses short low or high excursions before any edge is measured. Sync leading edges (falling edges of the filtered stream) are then timed against the last edge. Only edges that fall inside a window around the nominal line period count as good lines. Lock hysteresis turns the stream of good and bad line events into the flag.

Top module: `sync_lock_qual`

## Requirements
- R1: After reset, `los` and `blank_en` are 1 and `bp_strobe` is 1 for the first `STROBE_W` clocks.
- R2: With `filt_en` = 1, the filtered stream takes a new level only after `sync_n` has held that level for `FILT_LEN` consecutive clock samples. A low pulse of `FILT_LEN` - 1 clocks is ignored, while a pulse of `FILT_LEN` clocks is seen as a sync edge.
- R3: With `filt_en` = 0, the filter is bypassed with no added delay, and a low pulse of any width is seen as a sync edge.
- R4: A sync edge whose spacing from the previous edge is within `NOM_PERIOD` ± `WIN_TOL` clocks counts as a good line. An edge outside that window counts as a bad line. The first edge after a timeout only sets the timing reference.
- R5: `los` goes to 0 on the clock edge that registers the `LOCK_LINES`-th consecutive good line while unlocked (default 8).
- R6: While locked, `DROP_LINES` consecutive bad lines set `los` to 1 (default 4). A bad line is an out-of-window edge or a timeout after `NOM_PERIOD` + `WIN_TOL` + 1 clocks with no edge.
- R7: `blank_en` always equals `los`, so the sync outputs are blanked whenever lock is absent.
- R8: While `los` is 1, `bp_strobe` is high for the first `STROBE_W` clocks of each `NOM_PERIOD`-clock free-running cycle. While locked it stays 0.
- R9: A bad line seen while unlocked clears the count of good lines, so lock again needs `LOCK_LINES` fresh consecutive good lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Sliced composite sync, low during sync tips |
| filt_en | input | 1 | 1 enables the minimum-width filter, 0 bypasses it |
| los | output | 1 | Loss of signal, 1 while unlocked |
| blank_en | output | 1 | Blank enable for downstream sync outputs |
| bp_strobe | output | 1 | Substitute restore strobe, active while unlocked |

## Verification
The assertions assume `sync_n` is already synchronous to the oscillator clock. They also assume `filt_en` changes only between clock edges, so the filter check can compare each level change against the input held on the previous edge. The stimulus changes both inputs only on falling clock edges. It switches `filt_en` only while `sync_n` is high, which keeps the bypass switch from creating a false edge. The line patterns place edges on both sides of the window limits, put glitches of one clock below and exactly at the filter length, and let the timeout fire on an idle input, so every path into and out of lock is driven.

// File: rtl/slq_pkg.sv
package slq_pkg;

  typedef enum logic [1:0] {
    LINE_NONE = 2'd0,
    LINE_GOOD = 2'd1,
    LINE_BAD  = 2'd2
  } line_evt_e;

  // spacing measured between two sync leading edges lies inside the window
  function automatic logic spacing_ok(input int unsigned meas,
                                      input int unsigned nom,
                                      input int unsigned tol);
    return ((meas + tol) >= nom) && (meas <= (nom + tol));
  endfunction

  // clock count after the last edge at which a missing line is declared
  function automatic int unsigned timeout_count(input int unsigned nom,
                                                input int unsigned tol);
    return nom + tol + 1;
  endfunction

  // substitute restore strobe is active in the head of each free-running cycle
  function automatic logic strobe_phase(input int unsigned phase,
                                        input int unsigned width);
    return phase < width;
  endfunction

endpackage

// File: rtl/slq_glitch.sv
module slq_glitch #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic sync_n,
  output logic filt_sync
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;

  logic          held;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b1;
      run  <= '0;
    end else if (!filt_en) begin
      held <= sync_n;
      run  <= '0;
    end else if (sync_n != held) begin
      if (run == CW'(FILT_LEN - 1)) begin
        held <= sync_n;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else begin
      run <= '0;
    end
  end

  assign filt_sync = filt_en ? held : sync_n;

endmodule

// File: rtl/slq_period.sv
module slq_period
  import slq_pkg::*;
#(
  parameter int unsigned NOM_PERIOD = 508,
  parameter int unsigned WIN_TOL    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_sync,
  output logic good_evt,
  output logic bad_evt
);
  localparam int unsigned LATE = timeout_count(NOM_PERIOD, WIN_TOL);
  localparam int unsigned SW   = $clog2(LATE + 1);

  logic          prev_lvl;
  logic          ref_ok;
  logic [SW-1:0] since;
  logic          fall;
  logic          late;
  logic          in_win;
  line_evt_e     evt;

  assign fall   = prev_lvl & ~filt_sync;
  assign late   = (since == SW'(LATE));
  assign in_win = spacing_ok(32'(since), NOM_PERIOD, WIN_TOL);

  always_comb begin
    evt = LINE_NONE;
    if (fall) begin
      if (ref_ok) evt = in_win ? LINE_GOOD : LINE_BAD;
    end else if (late) begin
      evt = LINE_BAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= 1'b1;
      ref_ok   <= 1'b0;
      since    <= '0;
    end else begin
      prev_lvl <= filt_sync;
      if (fall) begin
        since  <= SW'(1);
        ref_ok <= 1'b1;
      end else if (late) begin
        since  <= SW'(1);
        ref_ok <= 1'b0;
      end else begin
        since <= since + 1'b1;
      end
    end
  end

  assign good_evt = (evt == LINE_GOOD);
  assign bad_evt  = (evt == LINE_BAD);

endmodule

// File: rtl/slq_lock.sv
module slq_lock #(
  parameter int unsigned LOCK_LINES = 8,
  parameter int unsigned DROP_LINES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_evt,
  input  logic bad_evt,
  output logic los
);
  localparam int unsigned GW = $clog2(LOCK_LINES + 1);
  localparam int unsigned BW = $clog2(DROP_LINES + 1);

  logic          locked;
  logic [GW-1:0] good_run;
  logic [BW-1:0] bad_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      good_run <= '0;
      bad_run  <= '0;
    end else if (!locked) begin
      bad_run <= '0;
      if (bad_evt) begin
        good_run <= '0;
      end else if (good_evt) begin
        if (good_run == GW'(LOCK_LINES - 1)) begin
          locked   <= 1'b1;
          good_run <= '0;
        end else begin
          good_run <= good_run + 1'b1;
        end
      end
    end else begin
      good_run <= '0;
      if (good_evt) begin
        bad_run <= '0;
      end else if (bad_evt) begin
        if (bad_run == BW'(DROP_LINES - 1)) begin
          locked  <= 1'b0;
          bad_run <= '0;
        end else begin
          bad_run <= bad_run + 1'b1;
        end
      end
    end
  end

  assign los = ~locked;

endmodule

// File: rtl/slq_restore.sv
module slq_restore
  import slq_pkg::*;
#(
  parameter int unsigned NOM_PERIOD = 508,
  parameter int unsigned STROBE_W   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic los,
  output logic bp_strobe
);
  localparam int unsigned PW = $clog2(NOM_PERIOD);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           phase <= '0;
    else if (phase == PW'(NOM_PERIOD - 1)) phase <= '0;
    else                                  phase <= phase + 1'b1;
  end

  assign bp_strobe = los & strobe_phase(32'(phase), STROBE_W);

endmodule

// File: rtl/sync_lock_qual.sv
module sync_lock_qual #(
  parameter int unsigned NOM_PERIOD = 508,
  parameter int unsigned WIN_TOL    = 32,
  parameter int unsigned FILT_LEN   = 16,
  parameter int unsigned LOCK_LINES = 8,
  parameter int unsigned DROP_LINES = 4,
  parameter int unsigned STROBE_W   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic filt_en,
  output logic los,
  output logic blank_en,
  output logic bp_strobe
);
  // internal events brought out by name for the bound checker
  logic filt_sync;
  logic good_evt;
  logic bad_evt;

  slq_glitch #(.FILT_LEN(FILT_LEN)) i_glitch (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .sync_n(sync_n),
    .filt_sync(filt_sync)
  );

  slq_period #(.NOM_PERIOD(NOM_PERIOD), .WIN_TOL(WIN_TOL)) i_period (
    .clk(clk), .rst_n(rst_n), .filt_sync(filt_sync),
    .good_evt(good_evt), .bad_evt(bad_evt)
  );

  slq_lock #(.LOCK_LINES(LOCK_LINES), .DROP_LINES(DROP_LINES)) i_lock (
    .clk(clk), .rst_n(rst_n), .good_evt(good_evt), .bad_evt(bad_evt),
    .los(los)
  );

  slq_restore #(.NOM_PERIOD(NOM_PERIOD), .STROBE_W(STROBE_W)) i_restore (
    .clk(clk), .rst_n(rst_n), .los(los), .bp_strobe(bp_strobe)
  );

  assign blank_en = los;

endmodule

// File: rtl/slq_checker.sv
module slq_checker (
  input logic clk,
  input logic rst_n,
  input logic sync_n,
  input logic filt_en,
  input logic filt_sync,
  input logic good_evt,
  input logic bad_evt,
  input logic los,
  input logic blank_en,
  input logic bp_strobe
);

  AST_FILTER_LEVEL_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && $past(filt_en) && (filt_sync != $past(filt_sync))) |-> (filt_sync == $past(sync_n))); // R2

  AST_BYPASS_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_en && !$past(filt_en)) |-> ($past(filt_sync) == $past(sync_n))); // R3

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(good_evt && bad_evt)); // R4

  AST_LOCK_ON_GOOD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(good_evt)); // R5

  AST_DROP_ON_BAD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(bad_evt)); // R6

  AST_BLANK_TRACKS_LOS: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(los) |-> $changed(blank_en)); // R7

  AST_STROBE_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bp_strobe |-> los); // R8

endmodule

bind sync_lock_qual slq_checker i_slq_checker (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .filt_en(filt_en),
  .filt_sync(filt_sync), .good_evt(good_evt), .bad_evt(bad_evt),
  .los(los), .blank_en(blank_en), .bp_strobe(bp_strobe)
);

// File: tb/test_sync_lock_qual.sv
module test_sync_lock_qual;
  localparam int CLK_PERIOD = 10;
  localparam int NOM  = 508;
  localparam int TOL  = 32;
  localparam int FL   = 16;
  localparam int LK   = 8;
  localparam int DR   = 4;
  localparam int SW   = 32;
  localparam int LATE = NOM + TOL + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic filt_en = 1'b0;
  wire  los, blank_en, bp_strobe;

  int n_cmp = 0;
  int n_bad = 0;
  int hits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_lock_qual i_sync_lock_qual (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .filt_en(filt_en),
    .los(los), .blank_en(blank_en), .bp_strobe(bp_strobe)
  );

  // behavioural reference model
  int m_lvl, m_stable, m_last, m_gap, m_have_ref, m_locked, m_goods, m_bads, m_tick;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 1; m_stable = 0; m_last = 1; m_gap = 0; m_have_ref = 0;
      m_locked = 0; m_goods = 0; m_bads = 0; m_tick = 0;
    end else begin
      int seen;
      int verdict; // 0 none, 1 good, 2 bad
      seen = filt_en ? m_lvl : int'(sync_n);
      if (!filt_en) begin
        m_lvl = int'(sync_n); m_stable = 0;
      end else if (int'(sync_n) != m_lvl) begin
        m_stable++;
        if (m_stable == FL) begin m_lvl = int'(sync_n); m_stable = 0; end
      end else m_stable = 0;
      verdict = 0;
      if (m_last == 1 && seen == 0) begin
        if (m_have_ref != 0)
          verdict = (m_gap >= NOM - TOL && m_gap <= NOM + TOL) ? 1 : 2;
        m_gap = 1; m_have_ref = 1;
      end else if (m_gap == LATE) begin
        verdict = 2; m_gap = 1; m_have_ref = 0;
      end else m_gap++;
      m_last = seen;
      if (m_locked == 0) begin
        if (verdict == 2) m_goods = 0;
        else if (verdict == 1) begin
          m_goods++;
          if (m_goods == LK) begin m_locked = 1; m_goods = 0; end
        end
        m_bads = 0;
      end else begin
        if (verdict == 1) m_bads = 0;
        else if (verdict == 2) begin
          m_bads++;
          if (m_bads == DR) begin m_locked = 0; m_bads = 0; end
        end
      end
      m_tick = (m_tick + 1) % NOM;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e_los, e_bp;
      e_los = (m_locked != 0) ? 0 : 1;
      e_bp  = (e_los == 1 && m_tick < SW) ? 1 : 0;
      if (bp_strobe) hits++;
      n_cmp += 3;
      if (int'(los) != e_los) begin
        n_bad++; $display("FAIL R5/R6 los act=%0d exp=%0d t=%0t", los, e_los, $time);
      end
      if (int'(blank_en) != e_los) begin
        n_bad++; $display("FAIL R7 blank_en act=%0d exp=%0d t=%0t", blank_en, e_los, $time);
      end
      if (int'(bp_strobe) != e_bp) begin
        n_bad++; $display("FAIL R8 bp_strobe act=%0d exp=%0d t=%0t", bp_strobe, e_bp, $time);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic line(input int period, input int w, input int gpos = 0, input int gw = 0);
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      sync_n = (i < w || (gw > 0 && i >= gpos && i < gpos + gw)) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_n = 1'b1;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R5 act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    chk(int'(los), 1, "R1 los in reset");
    chk(int'(blank_en), 1, "R1 blank_en in reset");
    chk(int'(bp_strobe), 1, "R1 strobe in reset");
    rst_n = 1'b1;
    idle(20);
    chk(int'(bp_strobe), 1, "R1 strobe head after reset");

    // bypass: first edge sets reference, then 7 good lines
    repeat (8) line(NOM, 38);
    chk(int'(los), 1, "R5 no lock after 7 good lines");
    line(NOM, 38);
    chk(int'(los), 0, "R5 lock on 8th good line");
    chk(int'(blank_en), 0, "R7 blank released");
    h0 = hits;
    line(NOM, 38);
    chk(hits - h0, 0, "R8 strobe quiet while locked");

    // spacings at the window limits keep lock
    line(NOM + 30, 38);
    line(NOM - 30, 38);
    line(400, 38);
    chk(int'(los), 0, "R4 in-window spacings keep lock");
    repeat (3) line(400, 38);
    chk(int'(los), 0, "R6 still locked after 3 early edges");
    line(NOM, 38);
    chk(int'(los), 1, "R6 drop on 4th early edge");
    chk(int'(blank_en), 1, "R7 blank on drop");

    // a bad line breaks the good run while unlocked
    repeat (6) line(NOM, 38);
    line(300, 38);
    line(NOM, 38);
    repeat (7) line(NOM, 38);
    chk(int'(los), 1, "R9 good run restarted by bad line");
    line(NOM, 38);
    chk(int'(los), 0, "R9 lock after 8 fresh good lines");

    // timeouts
    idle(2 * LATE);
    chk(int'(los), 0, "R6 two timeouts keep lock");
    idle(600);
    chk(int'(los), 1, "R6 drop after 4 timeouts");
    h0 = hits;
    idle(NOM);
    chk(hits - h0, SW, "R8 strobe width per line while unlocked");

    // filter enabled
    filt_en = 1'b1;
    repeat (8) line(NOM, 38);
    chk(int'(los), 1, "R5 no lock before 8 filtered good lines");
    line(NOM, 38);
    chk(int'(los), 0, "R2 lock through filter");
    repeat (4) line(NOM, 38, 254, FL - 1);
    chk(int'(los), 0, "R2 short glitch ignored");
    repeat (2) line(NOM, 38, 254, FL);
    chk(int'(los), 0, "R2 three bad so far");
    line(NOM, 38, 254, FL);
    chk(int'(los), 1, "R2 full-length glitch counts as edge");

    repeat (9) line(NOM, 38);
    chk(int'(los), 0, "R2 relock with filter");

    // bypass: even a short glitch is an edge
    filt_en = 1'b0;
    repeat (2) line(NOM, 38, 254, 10);
    chk(int'(los), 0, "R3 three bad so far");
    line(NOM, 38, 254, 10);
    chk(int'(los), 1, "R3 short glitch seen in bypass");

    idle(4);
    summary();
    $finish;
  end

endmodule